// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block performs clause-22 style management transactions between a host and an Ethernet PHY over a two-wire MDC/MDIO link. Software writes one 32-bit frame word and the transaction starts on that write. The engine then produces the MDC clock and shifts a run of preamble ones onto MDIO, followed by the frame word, most significant bit first.

For a read, the engine stops driving MDIO once the register address has been sent. It does not act on the two turnaround bit times. It then samples the sixteen data bits returned by the PHY into the low half of the same frame word. When the last bit time ends, a sticky completion flag is raised, and software clears it with a one-cycle clear pulse. A speed field sets the MDC rate, and a speed of zero holds MDC still.

Frame word layout, from bit 31 down:

| Bits | Field |
|---|---|
| 31:30 | start pattern, written as 01 |
| 29:28 | operation: 01 is a write, 10 is a read |
| 27:23 | PHY address |
| 22:18 | register address |
| 17:16 | turnaround, written as 10 |
| 15:0 | data |

Top module: `mdio_frame_engine`

## Requirements
- R1: After reset, `busy`, `done`, `mdc` and `mdio_oe` are 0, `frame_q` is 0 and `speed_q` equals the parameter `SPEED_RST` (default 19).
- R2: A `frame_we` pulse while idle loads `frame_q` and sets `busy` at that clock edge. MDIO then carries 32 ones followed by `frame_q[31]` down to `frame_q[0]`, one bit per MDC period. Each bit is stable across its MDC rising edge.
- R3: With speed S > 0, MDC stays low for S clocks and high for S clocks, so its period is 2*S clocks. MDC is low whenever the engine is idle.
- R4: While the speed field is 0, MDC does not change and a transaction that is under way stays `busy`. Once the field is set nonzero, the transaction resumes and completes.
- R5: When frame bits 29:28 are not 10, `mdio_oe` stays 1 for all 64 bit times.
- R6: When frame bits 29:28 are 10 (read), `mdio_oe` is 1 for the first 46 bit times (preamble, start, opcode, both addresses) and 0 for the last 18. The level on `mdio_in` during the two turnaround bit times has no effect on the result.
- R7: After a read, `frame_q[15:0]` holds the 16 bits sampled from `mdio_in` at the MDC rising edges of the last 16 bit times, first bit into bit 15. `frame_q[31:16]` keeps its written value. After a write, `frame_q` is unchanged.
- R8: `busy` falls and `done` rises at the MDC falling edge that ends the 64th bit time. A transaction therefore lasts exactly 128*S clocks.
- R9: `done` stays set until a clock where `done_clr` is 1. If completion and `done_clr` arrive in the same clock, `done` ends that clock set.
- R10: A `frame_we` pulse while `busy` is ignored. Neither `frame_q` nor the bits on MDIO change because of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_we | input | 1 | Frame word write strobe; starts a transaction when idle |
| frame_wdata | input | 32 | Frame word to load |
| speed_we | input | 1 | Speed field write strobe |
| speed_wdata | input | SPEED_W | New speed value |
| done_clr | input | 1 | Clears the completion flag (write one to clear) |
| mdio_in | input | 1 | MDIO level seen from the pad |
| frame_q | output | 32 | Frame word readback, including read data |
| speed_q | output | SPEED_W | Speed field readback |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Sticky completion flag |
| mdc | output | 1 | Management clock to the PHY |
| mdio_out | output | 1 | MDIO drive value |
| mdio_oe | output | 1 | MDIO drive enable |

## Verification
The assertions assume that `frame_we`, `speed_we` and `done_clr` are synchronous to `clk`. They also assume that `mdio_in` changes only while MDC is low, which is when a PHY returns data. The bench's PHY responder changes `mdio_in` only on the negative clock edge after it has seen an MDC falling edge. That is at least half a system clock, and usually several clocks, before the next MDC rise. Speed changes in the bench happen only while the engine is idle, except in the stall test, which writes zero before a frame starts and a nonzero value while MDC is held low.

// File: rtl/mdio_fe_pkg.sv
package mdio_fe_pkg;
   localparam int FRAME_W = 32;
   localparam int OP_HI   = 29;
   localparam int OP_LO   = 28;
   localparam int DATA_W  = 16;
   // bits sent before MDIO is released on a read: start, op, phy, reg
   localparam int HDR_BITS = 14;

   typedef enum logic [1:0] {
      MOP_WRITE = 2'b01,
      MOP_READ  = 2'b10
   } mdio_op_e;

   function automatic logic frame_is_read(input logic [FRAME_W-1:0] f);
      return f[OP_HI:OP_LO] == MOP_READ;
   endfunction
endpackage

// File: rtl/mdio_fe_clkgen.sv
module mdio_fe_clkgen #(
   parameter int SPEED_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic [SPEED_W-1:0] speed,
   output logic               mdc,
   output logic               rise_tk,
   output logic               fall_tk
);
   if (SPEED_W < 1 || SPEED_W > 16) begin : g_bad_speed_w
      $error("mdio_fe_clkgen: SPEED_W out of range");
   end

   logic [SPEED_W-1:0] cnt;
   logic               run, toggle;

   assign run     = en && (speed != '0);
   assign toggle  = run && (cnt >= speed - SPEED_W'(1));
   assign rise_tk = toggle && !mdc;
   assign fall_tk = toggle && mdc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (!en) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (!run) begin
         cnt <= '0;
      end else if (toggle) begin
         cnt <= '0;
         mdc <= ~mdc;
      end else begin
         cnt <= cnt + SPEED_W'(1);
      end
   end

   // R3: MDC parks low once the engine is idle
   p_mdc_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !mdc);

   // R4: a zero speed freezes MDC
   p_speed0_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && speed == '0) |=> $stable(mdc));
endmodule

// File: rtl/mdio_fe_seq.sv
module mdio_fe_seq
   import mdio_fe_pkg::*;
#(
   parameter int PREAMBLE_LEN = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_we,
   input  logic [FRAME_W-1:0] frame_wdata,
   input  logic               rise_tk,
   input  logic               fall_tk,
   input  logic               mdio_in,
   output logic               busy,
   output logic [FRAME_W-1:0] frame_q,
   output logic               mdio_out,
   output logic               mdio_oe,
   output logic               finish
);
   localparam int TOTAL      = PREAMBLE_LEN + FRAME_W;
   localparam int IDX_W      = $clog2(TOTAL + 1);
   localparam int RELEASE_AT = PREAMBLE_LEN + HDR_BITS;
   localparam int DATA_AT    = PREAMBLE_LEN + FRAME_W - DATA_W;

   if (PREAMBLE_LEN < 0 || PREAMBLE_LEN > 64) begin : g_bad_pre
      $error("mdio_fe_seq: PREAMBLE_LEN out of range");
   end

   logic [IDX_W-1:0] idx;
   logic [IDX_W-1:0] fofs;
   logic [4:0]       fsel;
   logic             in_pre, is_rd, last_bit, frame_bit;

   if (PREAMBLE_LEN > 0) begin : g_pre
      assign in_pre = idx < IDX_W'(PREAMBLE_LEN);
   end else begin : g_nopre
      assign in_pre = 1'b0;
   end

   assign is_rd     = frame_is_read(frame_q);
   assign last_bit  = idx == IDX_W'(TOTAL - 1);
   assign finish    = busy && fall_tk && last_bit;
   assign fofs      = IDX_W'(PREAMBLE_LEN + FRAME_W - 1) - idx;
   assign fsel      = fofs[4:0];
   assign frame_bit = frame_q[fsel];

   always_comb begin
      mdio_oe = busy && (!is_rd || idx < IDX_W'(RELEASE_AT));
      if (!mdio_oe || in_pre) mdio_out = 1'b1;
      else                    mdio_out = frame_bit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         idx     <= '0;
         frame_q <= '0;
      end else if (!busy) begin
         if (frame_we) begin
            busy    <= 1'b1;
            idx     <= '0;
            frame_q <= frame_wdata;
         end
      end else begin
         if (rise_tk && is_rd && idx >= IDX_W'(DATA_AT))
            frame_q[DATA_W-1:0] <= {frame_q[DATA_W-2:0], mdio_in};
         if (fall_tk) begin
            if (last_bit) busy <= 1'b0;
            else          idx  <= idx + IDX_W'(1);
         end
      end
   end

   // R10: the header half never moves while a transfer runs
   p_upper_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(frame_q[FRAME_W-1:DATA_W]));

   // R2: the MDIO bit presented is stable across each MDC rise
   p_mdio_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rise_tk) |=> ($stable(mdio_out) && $stable(mdio_oe)));

   // R5: a write frame is driven for its whole length
   p_write_drives_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && frame_q[OP_HI:OP_LO] != MOP_READ) |-> mdio_oe);

   // R7: a write frame leaves the data half untouched
   p_write_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !is_rd) |=> $stable(frame_q[DATA_W-1:0]));
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
   import mdio_fe_pkg::*;
#(
   parameter int SPEED_W      = 6,
   parameter int SPEED_RST    = 19,
   parameter int PREAMBLE_LEN = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_we,
   input  logic [31:0]        frame_wdata,
   input  logic               speed_we,
   input  logic [SPEED_W-1:0] speed_wdata,
   input  logic               done_clr,
   input  logic               mdio_in,
   output logic [31:0]        frame_q,
   output logic [SPEED_W-1:0] speed_q,
   output logic               busy,
   output logic               done,
   output logic               mdc,
   output logic               mdio_out,
   output logic               mdio_oe
);
   if (SPEED_RST < 0 || SPEED_RST >= (1 << SPEED_W)) begin : g_bad_rst
      $error("mdio_frame_engine: SPEED_RST does not fit SPEED_W");
   end

   logic rise_tk, fall_tk, finish;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        speed_q <= SPEED_W'(SPEED_RST);
      else if (speed_we) speed_q <= speed_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        done <= 1'b0;
      else if (finish)   done <= 1'b1;
      else if (done_clr) done <= 1'b0;
   end

   mdio_fe_clkgen #(.SPEED_W(SPEED_W)) u_clkgen (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (busy),
      .speed   (speed_q),
      .mdc     (mdc),
      .rise_tk (rise_tk),
      .fall_tk (fall_tk)
   );

   mdio_fe_seq #(.PREAMBLE_LEN(PREAMBLE_LEN)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_we    (frame_we),
      .frame_wdata (frame_wdata),
      .rise_tk     (rise_tk),
      .fall_tk     (fall_tk),
      .mdio_in     (mdio_in),
      .busy        (busy),
      .frame_q     (frame_q),
      .mdio_out    (mdio_out),
      .mdio_oe     (mdio_oe),
      .finish      (finish)
   );

   // R8: completion flag follows the end of a transfer
   p_done_on_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R9: a clear pulse without a coincident completion empties the flag
   p_done_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_clr && !finish) |=> !done);

   // R9: the flag is sticky without a clear
   p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !done_clr) |=> done);
endmodule

// File: tb/mdio_frame_engine_bench.sv
module mdio_frame_engine_bench;
   localparam int SW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          frame_we = 1'b0;
   logic [31:0]   frame_wdata = '0;
   logic          speed_we = 1'b0;
   logic [SW-1:0] speed_wdata = '0;
   logic          done_clr = 1'b0;
   logic          mdio_in = 1'b1;
   logic [31:0]   frame_q;
   logic [SW-1:0] speed_q;
   logic          busy, done, mdc, mdio_out, mdio_oe;

   mdio_frame_engine #(.SPEED_W(SW)) u_mdio_frame_engine (
      .clk(clk), .rst_n(rst_n), .frame_we(frame_we), .frame_wdata(frame_wdata),
      .speed_we(speed_we), .speed_wdata(speed_wdata), .done_clr(done_clr),
      .mdio_in(mdio_in), .frame_q(frame_q), .speed_q(speed_q), .busy(busy),
      .done(done), .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe));

   always #2 clk = ~clk;   // 250 MHz

   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // PHY responder and monitor, all on the negative clock edge
   logic [15:0] phy_val = '0;
   logic        ta_val = 1'b1;
   logic [63:0] cap, oecap;
   int nrise, ncyc, pmin, pmax, last_rise;
   logic mdc_q = 1'b0, busy_q = 1'b0;

   always @(negedge clk) begin
      if (busy && !busy_q) begin
         nrise = 0; ncyc = 0; cap = '0; oecap = '0;
         pmin = 1000000; pmax = 0; last_rise = -1; mdc_q = 1'b0;
         mdio_in = 1'b1;
      end
      if (busy) ncyc++;
      if (mdc && !mdc_q) begin
         if (nrise < 64) begin
            cap[63-nrise]   = mdio_out;
            oecap[63-nrise] = mdio_oe;
         end
         if (last_rise >= 0) begin
            if (ncyc - last_rise < pmin) pmin = ncyc - last_rise;
            if (ncyc - last_rise > pmax) pmax = ncyc - last_rise;
         end
         last_rise = ncyc;
         nrise++;
      end
      if (!mdc && mdc_q) begin
         if (nrise >= 48 && nrise < 64) mdio_in = phy_val[63-nrise];
         else if (nrise == 46 || nrise == 47) mdio_in = ta_val;
         else mdio_in = 1'b1;
      end
      mdc_q  = mdc;
      busy_q = busy;
   end

   function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] pa,
                                      input logic [4:0] ra, input logic [15:0] d);
      return {2'b01, op, pa, ra, 2'b10, d};
   endfunction

   task automatic set_speed(input int s);
      @(negedge clk); #1;
      speed_we = 1'b1; speed_wdata = SW'(s);
      @(negedge clk); #1;
      speed_we = 1'b0;
   endtask

   task automatic write_frame(input logic [31:0] f);
      @(negedge clk); #1;
      frame_we = 1'b1; frame_wdata = f;
      @(negedge clk); #1;
      frame_we = 1'b0;
   endtask

   task automatic wait_idle();
      int guard = 0;
      @(negedge clk);
      while (busy && guard < 20000) begin
         @(negedge clk);
         guard++;
      end
   endtask

   task automatic clear_done();
      @(negedge clk); #1;
      done_clr = 1'b1;
      @(negedge clk); #1;
      done_clr = 1'b0;
   endtask

   task automatic run_txn(input logic [31:0] f, input logic [15:0] pd, input logic ta, input int s);
      logic [31:0] expq;
      logic [63:0] expoe;
      bit rd;
      rd = (f[29:28] == 2'b10);
      phy_val = pd; ta_val = ta;
      write_frame(f);
      wait_idle();
      expoe = rd ? {{46{1'b1}}, {18{1'b0}}} : {64{1'b1}};
      expq  = rd ? {f[31:16], pd} : f;
      if (rd) chk(cap[63:18] == {32'hFFFF_FFFF, f[31:18]}, "R2 header bits", cap[63:18], {32'hFFFF_FFFF, f[31:18]});
      else    chk(cap == {32'hFFFF_FFFF, f}, "R2 frame bits", cap, {32'hFFFF_FFFF, f});
      chk(oecap == expoe, rd ? "R6 read drive window" : "R5 write drive window", oecap, expoe);
      chk(nrise == 64, "R2 bit count", nrise, 64);
      chk(pmin == 2*s && pmax == 2*s, "R3 mdc period", pmax, 2*s);
      chk(ncyc == 128*s, "R8 duration", ncyc, 128*s);
      chk(frame_q == expq, "R7 readback", frame_q, expq);
      chk(done == 1'b1, "R8 done set", done, 1);
      chk(mdc == 1'b0 && mdio_oe == 1'b0, "R3 idle mdc low", {mdc, mdio_oe}, 0);
      clear_done();
      chk(done == 1'b0, "R9 done cleared", done, 0);
   endtask

   // watchdog
   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 190000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual %0d expected <190000", wd);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(busy == 0 && done == 0 && mdc == 0 && mdio_oe == 0, "R1 reset ctrl", {busy, done, mdc, mdio_oe}, 0);
      chk(frame_q == 0, "R1 reset frame", frame_q, 0);
      chk(speed_q == SW'(19), "R1 reset speed", speed_q, 19);
      #1 rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // sweep of speeds and frame shapes
      for (int s = 1; s <= 4; s++) begin
         set_speed(s);
         run_txn(mk(2'b01, 5'd1, 5'd0, 16'hA5C3), 16'h0, 1'b1, s);
         run_txn(mk(2'b01, 5'd31, 5'd31, 16'h0001), 16'h0, 1'b0, s);
         run_txn(mk(2'b10, 5'd3, 5'd2, 16'h0000), 16'h8001, 1'b1, s);        // R6 ta driven 1
         run_txn(mk(2'b10, 5'd16, 5'd9, 16'hFFFF), 16'h3C5A + 16'(s), 1'b0, s); // R6 ta driven 0
      end

      // R10: a second write during a transfer is ignored
      begin
         logic [31:0] fa, fb;
         set_speed(1);
         fa = mk(2'b01, 5'd7, 5'd4, 16'h1234);
         fb = mk(2'b10, 5'd9, 5'd9, 16'hBEEF);
         write_frame(fa);
         repeat (20) @(negedge clk);
         write_frame(fb);
         chk(frame_q == fa, "R10 frame held mid-transfer", frame_q, fa);
         wait_idle();
         chk(cap == {32'hFFFF_FFFF, fa}, "R10 bits unaffected", cap, {32'hFFFF_FFFF, fa});
         chk(frame_q == fa, "R10 frame after", frame_q, fa);
         clear_done();
      end

      // R4: zero speed stalls, nonzero resumes
      begin
         logic [31:0] fc;
         fc = mk(2'b10, 5'd2, 5'd1, 16'h0);
         phy_val = 16'h6E91; ta_val = 1'b1;
         set_speed(0);
         write_frame(fc);
         repeat (60) @(negedge clk);
         chk(mdc == 1'b0 && nrise == 0, "R4 mdc frozen", {mdc, 8'(nrise)}, 0);
         chk(busy == 1'b1, "R4 still busy", busy, 1);
         set_speed(2);
         wait_idle();
         chk(frame_q == {fc[31:16], 16'h6E91}, "R4 resumed read", frame_q, {fc[31:16], 16'h6E91});
         chk(pmin == 4 && pmax == 4, "R4 period after resume", pmax, 4);
         clear_done();
      end

      // R9: clear held across completion; set wins
      begin
         set_speed(1);
         write_frame(mk(2'b01, 5'd5, 5'd5, 16'h5555));
         @(negedge clk); #1;
         done_clr = 1'b1;
         wait_idle();
         chk(done == 1'b1, "R9 set wins over clear", done, 1);
         @(negedge clk);
         chk(done == 1'b0, "R9 cleared next clock", done, 0);
         #1 done_clr = 1'b0;
         // R9: sticky without clear
         write_frame(mk(2'b01, 5'd5, 5'd6, 16'h0));
         wait_idle();
         repeat (30) @(negedge clk);
         chk(done == 1'b1, "R9 sticky", done, 1);
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule